// File: doc/BRIEF.md
# CPU Processor-State Sequencer

This block is the top-level sequencer that decides what a small 32-bit CPU core is doing. It keeps the core in one of five states and moves between them on a few inputs. The states are reset, exception entry, bus handed away, running, and low-power sleep. The inputs are a reset pin and a reset-type select, the exception and interrupt requests with their cause offsets, an external bus request and a sleep request. When the core leaves reset, the block gives the fetch unit its first address. When an exception or interrupt is taken, it raises the load strobes that copy the live PC, SR and R15 into their saved copies in a single cycle. It also writes a privileged SR value and issues a branch to the vector base plus the cause offset.

Peripherals see two reset outputs. The general one is asserted for both reset types. The second one, for the bus/DRAM controller, is asserted only for a power-on reset, so a manual reset leaves DRAM refresh running. While an external master owns the bus, the block raises the bus grant, and on return it leaves the PC untouched.

Top module: `cpu_state_seq`

## Requirements
- R1: `state_o` reports the current state with the codes reset=0, exception entry=1, bus released=2, running=3, sleep=4, and no other value ever appears.
- R2: Driving `rst_pin_n` low puts the block in the reset state at once, from any state. The block stays in reset until the pin has been high for two rising clock edges.
- R3: While in reset, `periph_rst_o` is high. `busc_rst_o` is high when `rst_kind_sel` was high during reset (power-on reset) and low when it was low (manual reset).
- R4: In the last reset cycle, `pc_load_o` is high with `next_pc_o` = 32'hA000_0000, and the next state is running.
- R5: Taking an exception or interrupt gives exactly one cycle in exception entry. In that cycle `spc_we_o`, `ssr_we_o` and `sgr_we_o` are all high, and `spc_d_o`, `ssr_d_o` and `sgr_d_o` equal `cur_pc`, `cur_sr` and `cur_r15`. In every other state these strobes are low.
- R6: In exception entry, `sr_load_o` is high and `sr_d_o` is `cur_sr` with bits 30 (privileged), 29 (register bank) and 28 (block) set.
- R7: In exception entry, `pc_load_o` is high with `next_pc_o` = `vec_base` + the zero-extended cause offset. The following state is running.
- R8: While running, the requests are served in this order: `exc_req` (offset `exc_off`), then `irq_req` (offset `irq_off`), then `bus_req`, then `sleep_req`. A low reset pin overrides all of them.
- R9: `sleep_req` while running leads to sleep. Sleep is left only by `irq_req`, which passes through exception entry, or by reset. `exc_req` has no effect in sleep.
- R10: `bus_req` while running leads to the bus-released state with `bus_grant_o` high. In that state no PC load and no save strobe is issued, and `exc_req` and `irq_req` are ignored. When `bus_req` drops, the block returns to running with `bus_grant_o` low and no PC load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | Active-low reset pin, asynchronous assert |
| rst_kind_sel | input | 1 | Reset type: 1 power-on, 0 manual |
| exc_req | input | 1 | General exception request |
| exc_off | input | 12 | Exception cause offset |
| irq_req | input | 1 | Interrupt request, already masked |
| irq_off | input | 12 | Interrupt cause offset |
| vec_base | input | 32 | Vector base address |
| bus_req | input | 1 | External bus request |
| sleep_req | input | 1 | Sleep request |
| cur_pc | input | 32 | Live program counter |
| cur_sr | input | 32 | Live status register |
| cur_r15 | input | 32 | Live R15 |
| state_o | output | 3 | Current state code |
| pc_load_o | output | 1 | Load `next_pc_o` into the PC |
| next_pc_o | output | 32 | Next fetch address |
| spc_we_o | output | 1 | Saved-PC load strobe |
| spc_d_o | output | 32 | Saved-PC data |
| ssr_we_o | output | 1 | Saved-SR load strobe |
| ssr_d_o | output | 32 | Saved-SR data |
| sgr_we_o | output | 1 | Saved-R15 load strobe |
| sgr_d_o | output | 32 | Saved-R15 data |
| sr_load_o | output | 1 | SR write strobe |
| sr_d_o | output | 32 | New SR value |
| periph_rst_o | output | 1 | Peripheral reset, both reset types |
| busc_rst_o | output | 1 | Bus controller reset, power-on only |
| bus_grant_o | output | 1 | Bus granted to external master |

## Verification
The assertions take a few things for granted about the inputs. The request and offset inputs change only away from the rising edge. `bus_req` holds steady between edges, so a rise of the grant can be traced back to a request seen at the previous edge. Reset exit can only be checked once the pin has stayed high through the synchronizer. The bench drives every input on the falling edge and holds the reset pin low for several cycles before each release. Each request stays up for a whole cycle and is then withdrawn, so each scenario produces exactly one transition.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int unsigned XLEN = 32;

  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_EXC    = 3'd1,
    ST_BUSREL = 3'd2,
    ST_RUN    = 3'd3,
    ST_SLEEP  = 3'd4
  } psc_state_e;
endpackage

// File: rtl/psc_rst_ctrl.sv
module psc_rst_ctrl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_pin_n,
  input  logic rst_kind_sel,
  output logic rst_sync_n,
  output logic kind_pon
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   kind_q;
  logic                   kind_en;

  // Assert asynchronously, release through the synchronizer chain.
  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) sync_q <= '0;
    else            sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  // Reset type is captured on every edge while reset is held.
  assign kind_en = !rst_sync_n;

  always_ff @(posedge clk) begin
    if (kind_en) kind_q <= rst_kind_sel;
  end

  assign kind_pon = kind_q;
endmodule

// File: rtl/psc_fsm.sv
module psc_fsm
  import psc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_pin_n,
  input  logic       rst_sync_n,
  input  logic       exc_req,
  input  logic       irq_req,
  input  logic       bus_req,
  input  logic       sleep_req,
  output psc_state_e state,
  output logic       cause_ld,
  output logic       cause_is_exc
);
  psc_state_e state_q, state_d;

  always_comb begin
    state_d      = state_q;
    cause_ld     = 1'b0;
    cause_is_exc = 1'b0;
    unique case (state_q)
      ST_RESET: begin
        if (rst_sync_n) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (exc_req) begin
          state_d      = ST_EXC;
          cause_ld     = 1'b1;
          cause_is_exc = 1'b1;
        end else if (irq_req) begin
          state_d  = ST_EXC;
          cause_ld = 1'b1;
        end else if (bus_req) begin
          state_d = ST_BUSREL;
        end else if (sleep_req) begin
          state_d = ST_SLEEP;
        end
      end
      ST_EXC:    state_d = ST_RUN;
      ST_BUSREL: if (!bus_req) state_d = ST_RUN;
      ST_SLEEP: begin
        if (irq_req) begin
          state_d  = ST_EXC;
          cause_ld = 1'b1;
        end
      end
      default:   state_d = ST_RESET;
    endcase
    if (!rst_sync_n) begin
      state_d  = ST_RESET;
      cause_ld = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) state_q <= ST_RESET;
    else            state_q <= state_d;
  end

  assign state = state_q;

  // R9: sleep is left only toward exception entry or reset
  a_r9_sleep_exit: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (state_q == ST_SLEEP) |=> (state_q inside {ST_SLEEP, ST_EXC, ST_RESET}));

  // R7: exception entry is transient
  a_r7_exc_one_cycle: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (state_q == ST_EXC && rst_sync_n) |=> (state_q inside {ST_RUN, ST_RESET}));
endmodule

// File: rtl/psc_vector.sv
module psc_vector #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst_pin_n,
  input  logic             cause_ld,
  input  logic             cause_is_exc,
  input  logic [OFF_W-1:0] exc_off,
  input  logic [OFF_W-1:0] irq_off,
  input  logic [XLEN-1:0]  vec_base,
  output logic [XLEN-1:0]  target
);
  localparam int unsigned PAD_W = XLEN - OFF_W;

  logic [OFF_W-1:0] off_q, off_d;

  assign off_d = cause_is_exc ? exc_off : irq_off;

  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n)    off_q <= '0;
    else if (cause_ld) off_q <= off_d;
  end

  assign target = vec_base + {{PAD_W{1'b0}}, off_q};
endmodule

// File: rtl/cpu_state_seq.sv
module cpu_state_seq
  import psc_pkg::*;
#(
  parameter int unsigned OFF_W       = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] RESET_VEC   = 32'hA000_0000,
  parameter logic [31:0] SR_ENTRY    = 32'h7000_0000
) (
  input  logic             clk,
  input  logic             rst_pin_n,
  input  logic             rst_kind_sel,
  input  logic             exc_req,
  input  logic [OFF_W-1:0] exc_off,
  input  logic             irq_req,
  input  logic [OFF_W-1:0] irq_off,
  input  logic [31:0]      vec_base,
  input  logic             bus_req,
  input  logic             sleep_req,
  input  logic [31:0]      cur_pc,
  input  logic [31:0]      cur_sr,
  input  logic [31:0]      cur_r15,
  output logic [2:0]       state_o,
  output logic             pc_load_o,
  output logic [31:0]      next_pc_o,
  output logic             spc_we_o,
  output logic [31:0]      spc_d_o,
  output logic             ssr_we_o,
  output logic [31:0]      ssr_d_o,
  output logic             sgr_we_o,
  output logic [31:0]      sgr_d_o,
  output logic             sr_load_o,
  output logic [31:0]      sr_d_o,
  output logic             periph_rst_o,
  output logic             busc_rst_o,
  output logic             bus_grant_o
);
  logic       rst_sync_n;
  logic       kind_pon;
  psc_state_e state;
  logic       cause_ld;
  logic       cause_is_exc;
  logic [31:0] target;
  logic       in_exc;
  logic       in_reset;
  logic       reset_exit;

  psc_rst_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk          (clk),
    .rst_pin_n    (rst_pin_n),
    .rst_kind_sel (rst_kind_sel),
    .rst_sync_n   (rst_sync_n),
    .kind_pon     (kind_pon)
  );

  psc_fsm u_fsm (
    .clk          (clk),
    .rst_pin_n    (rst_pin_n),
    .rst_sync_n   (rst_sync_n),
    .exc_req      (exc_req),
    .irq_req      (irq_req),
    .bus_req      (bus_req),
    .sleep_req    (sleep_req),
    .state        (state),
    .cause_ld     (cause_ld),
    .cause_is_exc (cause_is_exc)
  );

  psc_vector #(.XLEN(XLEN), .OFF_W(OFF_W)) u_vec (
    .clk          (clk),
    .rst_pin_n    (rst_pin_n),
    .cause_ld     (cause_ld),
    .cause_is_exc (cause_is_exc),
    .exc_off      (exc_off),
    .irq_off      (irq_off),
    .vec_base     (vec_base),
    .target       (target)
  );

  assign in_exc     = (state == ST_EXC);
  assign in_reset   = (state == ST_RESET);
  assign reset_exit = in_reset && rst_sync_n;

  assign state_o      = state;
  assign pc_load_o    = in_exc || reset_exit;
  assign next_pc_o    = in_exc ? target : RESET_VEC;
  assign spc_we_o     = in_exc;
  assign ssr_we_o     = in_exc;
  assign sgr_we_o     = in_exc;
  assign spc_d_o      = cur_pc;
  assign ssr_d_o      = cur_sr;
  assign sgr_d_o      = cur_r15;
  assign sr_load_o    = in_exc;
  assign sr_d_o       = cur_sr | SR_ENTRY;
  assign periph_rst_o = in_reset;
  assign busc_rst_o   = in_reset && kind_pon;
  assign bus_grant_o  = (state == ST_BUSREL);

  // R1: only the five defined codes
  a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_pin_n)
    state_o <= 3'd4);

  // R3: bus controller reset is a subset of peripheral reset
  a_r3_busc_subset: assert property (@(posedge clk) disable iff (!rst_pin_n)
    busc_rst_o |-> periph_rst_o);

  // R4: leaving reset is preceded by a load of the reset vector
  a_r4_reset_vector: assert property (@(posedge clk) disable iff (!rst_pin_n)
    ($past(state_o) == 3'd0 && state_o == 3'd3) |->
      $past(pc_load_o && next_pc_o == RESET_VEC));

  // R5: save strobes only after running or sleep
  a_r5_save_origin: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(spc_we_o) |-> ($past(state_o) == 3'd3 || $past(state_o) == 3'd4));

  // R10: grant only follows a request
  a_r10_grant_req: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(bus_grant_o) |-> $past(bus_req));

  // R10: no PC load while the bus is released
  a_r10_no_load: assert property (@(posedge clk) disable iff (!rst_pin_n)
    bus_grant_o |-> !pc_load_o && !spc_we_o);
endmodule

// File: tb/cpu_state_seq_tb_top.sv
module cpu_state_seq_tb_top;
  localparam logic [2:0] S_RST = 3'd0, S_EXC = 3'd1, S_BUS = 3'd2, S_RUN = 3'd3, S_SLP = 3'd4;

  logic        clk = 1'b0;
  logic        rst_pin_n, rst_kind_sel, exc_req, irq_req, bus_req, sleep_req;
  logic [11:0] exc_off, irq_off;
  logic [31:0] vec_base, cur_pc, cur_sr, cur_r15;
  logic [2:0]  state_o;
  logic        pc_load_o, spc_we_o, ssr_we_o, sgr_we_o, sr_load_o;
  logic        periph_rst_o, busc_rst_o, bus_grant_o;
  logic [31:0] next_pc_o, spc_d_o, ssr_d_o, sgr_d_o, sr_d_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  cpu_state_seq dut_i (
    .clk(clk), .rst_pin_n(rst_pin_n), .rst_kind_sel(rst_kind_sel),
    .exc_req(exc_req), .exc_off(exc_off), .irq_req(irq_req), .irq_off(irq_off),
    .vec_base(vec_base), .bus_req(bus_req), .sleep_req(sleep_req),
    .cur_pc(cur_pc), .cur_sr(cur_sr), .cur_r15(cur_r15),
    .state_o(state_o), .pc_load_o(pc_load_o), .next_pc_o(next_pc_o),
    .spc_we_o(spc_we_o), .spc_d_o(spc_d_o), .ssr_we_o(ssr_we_o), .ssr_d_o(ssr_d_o),
    .sgr_we_o(sgr_we_o), .sgr_d_o(sgr_d_o), .sr_load_o(sr_load_o), .sr_d_o(sr_d_o),
    .periph_rst_o(periph_rst_o), .busc_rst_o(busc_rst_o), .bus_grant_o(bus_grant_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    exc_req = 0; irq_req = 0; bus_req = 0; sleep_req = 0;
  endtask

  // R2 R3 R4: reset entry, type, exit
  task automatic t_reset(input bit pon);
    @(negedge clk);
    rst_pin_n = 0; rst_kind_sel = pon; idle_inputs();
    #1 chk("R2 async entry", {29'd0, state_o}, {29'd0, S_RST});
    repeat (3) @(negedge clk);
    chk("R3 periph reset", {31'd0, periph_rst_o}, 32'd1);
    chk("R3 busc reset kind", {31'd0, busc_rst_o}, {31'd0, pon});
    rst_pin_n = 1;
    @(negedge clk);
    chk("R2 held after one edge", {29'd0, state_o}, {29'd0, S_RST});
    chk("R4 no load yet", {31'd0, pc_load_o}, 32'd0);
    @(negedge clk);
    chk("R4 load strobe", {31'd0, pc_load_o}, 32'd1);
    chk("R4 reset vector", next_pc_o, 32'hA000_0000);
    @(negedge clk);
    chk("R4 running", {29'd0, state_o}, {29'd0, S_RUN});
    chk("R3 periph released", {31'd0, periph_rst_o}, 32'd0);
  endtask

  // R5 R6 R7: check the entry cycle and the return
  task automatic expect_entry(input string tag, input logic [31:0] tgt);
    chk({tag, " R5 state entry"}, {29'd0, state_o}, {29'd0, S_EXC});
    chk({tag, " R5 strobes"}, {29'd0, spc_we_o, ssr_we_o, sgr_we_o}, 32'd7);
    chk({tag, " R5 saved pc"}, spc_d_o, cur_pc);
    chk({tag, " R5 saved sr"}, ssr_d_o, cur_sr);
    chk({tag, " R5 saved r15"}, sgr_d_o, cur_r15);
    chk({tag, " R6 sr write"}, {31'd0, sr_load_o}, 32'd1);
    chk({tag, " R6 sr value"}, sr_d_o, cur_sr | 32'h7000_0000);
    chk({tag, " R7 pc load"}, {31'd0, pc_load_o}, 32'd1);
    chk({tag, " R7 target"}, next_pc_o, tgt);
    @(negedge clk);
    chk({tag, " R7 back to run"}, {29'd0, state_o}, {29'd0, S_RUN});
    chk({tag, " R5 strobes low"}, {29'd0, spc_we_o, ssr_we_o, sgr_we_o}, 32'd0);
  endtask

  task automatic t_exception();
    @(negedge clk);
    cur_pc = 32'h8C00_1234; cur_sr = 32'h0000_00F1; cur_r15 = 32'h8CFF_FFF0;
    vec_base = 32'h8C00_0000; exc_off = 12'h100; exc_req = 1;
    @(negedge clk);
    exc_req = 0;
    expect_entry("exc", 32'h8C00_0100);
  endtask

  task automatic t_priority();
    @(negedge clk);
    cur_pc = 32'h0000_4000; cur_sr = 32'h4000_0002; cur_r15 = 32'h1111_2222;
    vec_base = 32'h8000_0000; exc_off = 12'h400; irq_off = 12'h600;
    exc_req = 1; irq_req = 1; bus_req = 1; sleep_req = 1;
    @(negedge clk);
    idle_inputs();
    expect_entry("R8 exc over irq", 32'h8000_0400);
    @(negedge clk);
    irq_req = 1; bus_req = 1; sleep_req = 1; irq_off = 12'hFFF; vec_base = 32'hFFFF_F000;
    @(negedge clk);
    idle_inputs();
    expect_entry("R8 irq over bus", 32'hFFFF_FFFF);
  endtask

  task automatic t_sleep();
    @(negedge clk);
    sleep_req = 1;
    @(negedge clk);
    sleep_req = 0;
    chk("R9 asleep", {29'd0, state_o}, {29'd0, S_SLP});
    exc_req = 1; exc_off = 12'h0AA;
    @(negedge clk);
    exc_req = 0;
    chk("R9 exc ignored", {29'd0, state_o}, {29'd0, S_SLP});
    chk("R9 no save on exc", {31'd0, spc_we_o}, 32'd0);
    cur_pc = 32'h0000_0800; vec_base = 32'h1000_0000; irq_off = 12'h600; irq_req = 1;
    @(negedge clk);
    irq_req = 0;
    expect_entry("R9 wake", 32'h1000_0600);
  endtask

  task automatic t_bus();
    @(negedge clk);
    bus_req = 1;
    @(negedge clk);
    chk("R10 released", {29'd0, state_o}, {29'd0, S_BUS});
    chk("R10 grant", {31'd0, bus_grant_o}, 32'd1);
    exc_req = 1; irq_req = 1;
    @(negedge clk);
    exc_req = 0; irq_req = 0;
    chk("R10 requests ignored", {29'd0, state_o}, {29'd0, S_BUS});
    chk("R10 no load", {30'd0, pc_load_o, spc_we_o}, 32'd0);
    bus_req = 0;
    @(negedge clk);
    chk("R10 returned", {29'd0, state_o}, {29'd0, S_RUN});
    chk("R10 grant low", {31'd0, bus_grant_o}, 32'd0);
    chk("R10 pc unchanged", {31'd0, pc_load_o}, 32'd0);
  endtask

  task automatic t_reset_wins();
    @(negedge clk);
    exc_req = 1; irq_req = 1; rst_pin_n = 0; rst_kind_sel = 0;
    @(negedge clk);
    chk("R8 reset over exc", {29'd0, state_o}, {29'd0, S_RST});
    chk("R5 no save in reset", {31'd0, spc_we_o}, 32'd0);
    idle_inputs();
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_pin_n = 0; rst_kind_sel = 1; idle_inputs();
    exc_off = '0; irq_off = '0; vec_base = '0; cur_pc = '0; cur_sr = '0; cur_r15 = '0;
    t_reset(1'b1);
    t_exception();
    t_priority();
    t_sleep();
    t_bus();
    t_reset_wins();
    t_reset(1'b0);
    t_exception();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule